// File: doc/BRIEF.md
# Level-Aware Interrupt Router

This block takes a group of external interrupt pins and turns each into an interrupt message. Each pin has its own 64-bit routing entry. The entry supplies the message vector, the delivery mode, the destination and the destination mode. It also selects how the pin is detected: the trigger type, the active polarity and a mask. Software programs the entries through a plain write port. The addressed entry is always visible on a combinational read port.

Edge entries fire once for each inactive-to-active transition. Level entries fire while the pin is active, but each delivery sets a per-entry remote-pending flag. While that flag is set, the entry cannot fire again, even if the pin stays active.

An end-of-interrupt broadcast carries a vector. Every entry whose flag is set and whose vector matches has its flag cleared. If the pin of such an entry is still active and the entry is unmasked, it is delivered again. Deliverable entries leave one message per cycle, lowest pin index first.

Top module: `irq_router`

## Requirements
- R1: After reset every entry reads 64'h0000_0000_0001_0000 (only the mask bit set) and no message is issued.
- R2: Entry layout: vector in bits 7:0, delivery mode 10:8, destination mode 11, polarity 13, remote-pending 14, trigger 15 (0 edge, 1 level), mask 16, destination 63:56. A message carries the vector, delivery mode, destination mode, destination and trigger of the entry that produced it.
- R3: A pin counts as active when its level differs from the polarity bit: 0 means active-high, 1 means active-low.
- R4: An edge entry records a pending request on each inactive-to-active transition. The request is delivered once and then cleared, with the message valid after the second rising clock edge that follows the pin change.
- R5: Delivering a level entry sets its remote-pending bit. While that bit is set, the entry issues no further message even with its pin held active.
- R6: An end-of-interrupt broadcast clears the remote-pending bit of each entry whose bit is set and whose vector equals the broadcast vector. Entries with other vectors are left unchanged.
- R7: A level entry whose remote-pending bit has just been cleared by a broadcast is delivered again if its pin is still active and the entry is unmasked.
- R8: A masked entry issues no message. An edge request that arrives while masked stays pending and is delivered after unmasking.
- R9: When several entries are deliverable in the same cycle, one message is issued per cycle, in order of lowest pin index first.
- R10: The remote-pending bit cannot be written through the register port: the written value of bit 14 is ignored.
- R11: The read port shows the full addressed entry combinationally, including the current remote-pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinIn | input | 8 | External interrupt pins |
| regWrEn | input | 1 | Entry write strobe |
| regAddr | input | 3 | Entry index for read and write |
| regWrData | input | 64 | Entry write data |
| regRdData | output | 64 | Addressed entry contents |
| eoiValid | input | 1 | End-of-interrupt broadcast strobe |
| eoiVector | input | 8 | Broadcast vector |
| msgValid | output | 1 | Message valid |
| msgVector | output | 8 | Message vector |
| msgDest | output | 8 | Message destination |
| msgDestMode | output | 1 | Message destination mode |
| msgDelMode | output | 3 | Message delivery mode |
| msgTrigger | output | 1 | Message trigger type (1 level) |

## Verification
A remote-pending bit stuck at 1 shows at the ports as a level interrupt that never returns after its matching broadcast. A bit stuck at 0 shows as repeated messages, one per cycle, from a held level pin. Both appear within two or three cycles of the delivery or broadcast, and the read port shows the bit directly. A wrong edge-pending state appears as a missing or duplicated message two edges after the pin change. A wrong priority shows in the order of back-to-back vectors.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int PIN_CNT   = 8;
  localparam int PIN_IDX_W = $clog2(PIN_CNT);
  localparam int ENTRY_W   = 64;
  localparam int VEC_W     = 8;
  localparam int DEST_W    = 8;
  localparam int DLV_W     = 3;

  // field positions inside a routing entry
  localparam int VEC_LSB   = 0;
  localparam int DLV_LSB   = 8;
  localparam int DMODE_BIT = 11;
  localparam int POL_BIT   = 13;
  localparam int RIRR_BIT  = 14;
  localparam int TRIG_BIT  = 15;
  localparam int MASK_BIT  = 16;
  localparam int DEST_LSB  = ENTRY_W - DEST_W;

  localparam logic [ENTRY_W-1:0] ENTRY_RESET = ENTRY_W'(1) << MASK_BIT;

  // strobes from control to datapath
  typedef struct packed {
    logic                 fire;
    logic [PIN_IDX_W-1:0] selIdx;
    logic [PIN_CNT-1:0]   eoiClr;
  } ctrlStrobe_t;
endpackage

// File: rtl/irq_router_ctrl.sv
module irq_router_ctrl
  import irq_router_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [PIN_CNT-1:0]            pendVec,
  input  logic [PIN_CNT-1:0]            maskVec,
  input  logic [PIN_CNT-1:0]            trigVec,
  input  logic [PIN_CNT-1:0]            rirrVec,
  input  logic [PIN_CNT-1:0][VEC_W-1:0] vecTab,
  input  logic                          eoiValid,
  input  logic [VEC_W-1:0]              eoiVector,
  output ctrlStrobe_t                   strobe
);
  logic [PIN_CNT-1:0] deliverable;
  logic [PIN_CNT-1:0] eoiHit;

  // an entry may fire when pending, unmasked, and not blocked by remote pending
  assign deliverable = pendVec & ~maskVec & ~(trigVec & rirrVec);

  always_comb begin
    strobe.selIdx = '0;
    for (int i = PIN_CNT - 1; i >= 0; i--) begin
      if (deliverable[i]) strobe.selIdx = PIN_IDX_W'(i);
    end
  end
  assign strobe.fire = |deliverable;

  for (genvar g = 0; g < PIN_CNT; g++) begin : g_eoi
    assign eoiHit[g] = eoiValid && rirrVec[g] && (vecTab[g] == eoiVector);
  end
  assign strobe.eoiClr = eoiHit;

  // R8: masked entries never selected
  p_mask_block_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fire |-> !maskVec[strobe.selIdx]);
  // R5: level entry with remote pending never selected
  p_rirr_block_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fire |-> !(trigVec[strobe.selIdx] && rirrVec[strobe.selIdx]));
  // R9: nothing with a lower index was deliverable
  p_lowest_first_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fire |-> ((pendVec & ~maskVec & ~(trigVec & rirrVec)
                      & ((PIN_CNT'(1) << strobe.selIdx) - PIN_CNT'(1))) == '0));
  // R6: a clear only targets entries holding the remote-pending bit
  p_eoi_target_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.eoiClr & ~rirrVec) == '0);
endmodule

// File: rtl/irq_router_dp.sv
module irq_router_dp
  import irq_router_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [PIN_CNT-1:0]            pinIn,
  input  logic                          regWrEn,
  input  logic [PIN_IDX_W-1:0]          regAddr,
  input  logic [ENTRY_W-1:0]            regWrData,
  output logic [ENTRY_W-1:0]            regRdData,
  input  ctrlStrobe_t                   strobe,
  output logic [PIN_CNT-1:0]            pendVec,
  output logic [PIN_CNT-1:0]            maskVec,
  output logic [PIN_CNT-1:0]            trigVec,
  output logic [PIN_CNT-1:0]            rirrVec,
  output logic [PIN_CNT-1:0][VEC_W-1:0] vecTab,
  output logic                          msgValid,
  output logic [VEC_W-1:0]              msgVector,
  output logic [DEST_W-1:0]             msgDest,
  output logic                          msgDestMode,
  output logic [DLV_W-1:0]              msgDelMode,
  output logic                          msgTrigger
);
  logic [ENTRY_W-1:0] entryQ [PIN_CNT];
  logic [ENTRY_W-1:0] entryNxt [PIN_CNT];
  logic [PIN_CNT-1:0] actNow;
  logic [PIN_CNT-1:0] actQ;
  logic [PIN_CNT-1:0] edgePendQ;
  logic [PIN_CNT-1:0] selHot;
  logic [ENTRY_W-1:0] selEntry;

  assign selHot = strobe.fire ? (PIN_CNT'(1) << strobe.selIdx) : '0;

  for (genvar g = 0; g < PIN_CNT; g++) begin : g_entry
    assign actNow[g]  = pinIn[g] ^ entryQ[g][POL_BIT];
    assign maskVec[g] = entryQ[g][MASK_BIT];
    assign trigVec[g] = entryQ[g][TRIG_BIT];
    assign rirrVec[g] = entryQ[g][RIRR_BIT];
    assign vecTab[g]  = entryQ[g][VEC_LSB +: VEC_W];
    assign pendVec[g] = entryQ[g][TRIG_BIT] ? actQ[g] : edgePendQ[g];

    always_comb begin
      entryNxt[g] = entryQ[g];
      if (regWrEn && (regAddr == PIN_IDX_W'(g))) begin
        entryNxt[g] = regWrData;
        entryNxt[g][RIRR_BIT] = entryQ[g][RIRR_BIT];
      end
      if (selHot[g] && entryQ[g][TRIG_BIT]) entryNxt[g][RIRR_BIT] = 1'b1;
      if (strobe.eoiClr[g]) entryNxt[g][RIRR_BIT] = 1'b0;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        entryQ[g]    <= ENTRY_RESET;
        actQ[g]      <= 1'b0;
        edgePendQ[g] <= 1'b0;
      end else begin
        entryQ[g] <= entryNxt[g];
        actQ[g]   <= actNow[g];
        if (actNow[g] && !actQ[g]) edgePendQ[g] <= 1'b1;
        else if (selHot[g])         edgePendQ[g] <= 1'b0;
      end
    end

    // R5: a level delivery leaves the remote-pending bit set
    p_level_sets_rirr_r5: assert property (@(posedge clk) disable iff (!rstN)
      (selHot[g] && trigVec[g]) |=> rirrVec[g]);
    // R6: a matched broadcast leaves the bit clear
    p_eoi_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
      strobe.eoiClr[g] |=> !rirrVec[g]);
    // R10: a write alone never moves the bit
    p_rirr_readonly_r10: assert property (@(posedge clk) disable iff (!rstN)
      (regWrEn && regAddr == PIN_IDX_W'(g) && !selHot[g] && !strobe.eoiClr[g])
        |=> $stable(rirrVec[g]));
  end

  assign selEntry  = entryQ[strobe.selIdx];
  assign regRdData = entryQ[regAddr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      msgValid    <= 1'b0;
      msgVector   <= '0;
      msgDest     <= '0;
      msgDestMode <= 1'b0;
      msgDelMode  <= '0;
      msgTrigger  <= 1'b0;
    end else begin
      msgValid <= strobe.fire;
      if (strobe.fire) begin
        msgVector   <= selEntry[VEC_LSB +: VEC_W];
        msgDest     <= selEntry[DEST_LSB +: DEST_W];
        msgDestMode <= selEntry[DMODE_BIT];
        msgDelMode  <= selEntry[DLV_LSB +: DLV_W];
        msgTrigger  <= selEntry[TRIG_BIT];
      end
    end
  end

  // R4: every selection yields exactly one message the next cycle
  p_msg_follows_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fire |=> msgValid);
  p_no_spurious_msg_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.fire |=> !msgValid);
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [PIN_CNT-1:0]   pinIn,
  input  logic                 regWrEn,
  input  logic [PIN_IDX_W-1:0] regAddr,
  input  logic [ENTRY_W-1:0]   regWrData,
  output logic [ENTRY_W-1:0]   regRdData,
  input  logic                 eoiValid,
  input  logic [VEC_W-1:0]     eoiVector,
  output logic                 msgValid,
  output logic [VEC_W-1:0]     msgVector,
  output logic [DEST_W-1:0]    msgDest,
  output logic                 msgDestMode,
  output logic [DLV_W-1:0]     msgDelMode,
  output logic                 msgTrigger
);
  ctrlStrobe_t                   strobe;
  logic [PIN_CNT-1:0]            pendVec;
  logic [PIN_CNT-1:0]            maskVec;
  logic [PIN_CNT-1:0]            trigVec;
  logic [PIN_CNT-1:0]            rirrVec;
  logic [PIN_CNT-1:0][VEC_W-1:0] vecTab;

  irq_router_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .pendVec   (pendVec),
    .maskVec   (maskVec),
    .trigVec   (trigVec),
    .rirrVec   (rirrVec),
    .vecTab    (vecTab),
    .eoiValid  (eoiValid),
    .eoiVector (eoiVector),
    .strobe    (strobe)
  );

  irq_router_dp i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .pinIn       (pinIn),
    .regWrEn     (regWrEn),
    .regAddr     (regAddr),
    .regWrData   (regWrData),
    .regRdData   (regRdData),
    .strobe      (strobe),
    .pendVec     (pendVec),
    .maskVec     (maskVec),
    .trigVec     (trigVec),
    .rirrVec     (rirrVec),
    .vecTab      (vecTab),
    .msgValid    (msgValid),
    .msgVector   (msgVector),
    .msgDest     (msgDest),
    .msgDestMode (msgDestMode),
    .msgDelMode  (msgDelMode),
    .msgTrigger  (msgTrigger)
  );
endmodule

// File: tb/test_irq_router.sv
module test_irq_router;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  pinIn = '0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [63:0] regWrData = '0;
  logic [63:0] regRdData;
  logic        eoiValid = 1'b0;
  logic [7:0]  eoiVector = '0;
  logic        msgValid;
  logic [7:0]  msgVector;
  logic [7:0]  msgDest;
  logic        msgDestMode;
  logic [2:0]  msgDelMode;
  logic        msgTrigger;

  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  // bench model state, built from the requirements
  logic [63:0] mEntry [NP];
  logic [7:0]  mAct;
  logic [7:0]  mEdge;
  logic        eValid;
  logic [20:0] eFields;   // {dest, vector, destMode, delMode, trigger}

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_router i_irq_router (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .eoiValid(eoiValid),
    .eoiVector(eoiVector), .msgValid(msgValid), .msgVector(msgVector),
    .msgDest(msgDest), .msgDestMode(msgDestMode), .msgDelMode(msgDelMode),
    .msgTrigger(msgTrigger)
  );

  function automatic logic [63:0] mkEntry(input logic [7:0] dest, input logic msk,
      input logic trig, input logic pol, input logic dmode, input logic [2:0] dlv,
      input logic [7:0] vec);
    logic [63:0] e = '0;
    e[63:56] = dest; e[16] = msk; e[15] = trig; e[13] = pol;
    e[11] = dmode; e[10:8] = dlv; e[7:0] = vec;
    return e;
  endfunction

  task automatic modelReset();
    for (int i = 0; i < NP; i++) mEntry[i] = 64'h0000_0000_0001_0000;
    mAct = '0; mEdge = '0; eValid = 1'b0; eFields = '0;
  endtask

  // advance the model by one clock edge using the current inputs
  task automatic modelStep();
    logic [7:0] act, pend, delv;
    int k = -1;
    for (int i = 0; i < NP; i++) begin
      act[i]  = pinIn[i] ^ mEntry[i][13];
      pend[i] = mEntry[i][15] ? mAct[i] : mEdge[i];
      delv[i] = pend[i] & ~mEntry[i][16] & ~(mEntry[i][15] & mEntry[i][14]);
    end
    for (int i = NP - 1; i >= 0; i--) if (delv[i]) k = i;
    eValid = (k >= 0);
    if (k >= 0)
      eFields = {mEntry[k][63:56], mEntry[k][7:0], mEntry[k][11], mEntry[k][10:8], mEntry[k][15]};
    for (int i = 0; i < NP; i++) begin
      logic [63:0] n = mEntry[i];
      logic clr = eoiValid && mEntry[i][14] && (mEntry[i][7:0] == eoiVector);
      if (regWrEn && regAddr == 3'(i)) n = {regWrData[63:15], mEntry[i][14], regWrData[13:0]};
      if (k == i && mEntry[i][15]) n[14] = 1'b1;
      if (clr) n[14] = 1'b0;
      if (act[i] && !mAct[i]) mEdge[i] = 1'b1;
      else if (k == i)        mEdge[i] = 1'b0;
      mEntry[i] = n;
    end
    mAct = act;
  endtask

  task automatic check(input string tag, input bit ok, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkMsg(input string tag);
    logic [20:0] got = {msgDest, msgVector, msgDestMode, msgDelMode, msgTrigger};
    check(tag, (msgValid === eValid) && (!eValid || got === eFields),
          {msgValid, 42'b0, got}, {eValid, 42'b0, eFields});
  endtask

  task automatic step(input string tag);
    modelStep();
    @(posedge clk);
    @(negedge clk);
    regWrEn = 1'b0;
    eoiValid = 1'b0;
    checkMsg(tag);
  endtask

  task automatic checkRead(input string tag, input int addr, input logic [63:0] exp);
    regAddr = 3'(addr);
    #1;
    check(tag, regRdData === exp, regRdData, exp);
  endtask

  task automatic writeEntry(input int addr, input logic [63:0] d);
    regWrEn = 1'b1; regAddr = 3'(addr); regWrData = d;
  endtask

  // counts messages carrying a given vector over a number of steps
  task automatic countVec(input string tag, input logic [7:0] vec, input int n, output int seen);
    seen = 0;
    for (int i = 0; i < n; i++) begin
      step(tag);
      if (msgValid && msgVector == vec) seen++;
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    int seen;
    void'($urandom(32'd4242));
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: reset contents and idle message port
    check("R1 msgValid", msgValid === 1'b0, {63'b0, msgValid}, 64'b0);
    for (int a = 0; a < NP; a++) checkRead("R1 entry", a, 64'h0000_0000_0001_0000);

    // R10: bit 14 written as 1 reads back 0
    writeEntry(0, mkEntry(8'h12, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 8'h31) | 64'h4000);
    step("R10 write");
    checkRead("R10 rirr ignored", 0, 64'h1200_0000_0000_0031);

    // R4: single message per edge, two edges after the pin change
    pinIn[0] = 1'b1;
    step("R4 first edge");
    check("R4 no early msg", msgValid === 1'b0, {63'b0, msgValid}, 64'b0);
    step("R4 second edge");
    check("R4 msg vector", msgValid === 1'b1 && msgVector === 8'h31, {55'b0, msgValid, msgVector}, {55'b0, 1'b1, 8'h31});
    countVec("R4 held pin", 8'h31, 4, seen);
    check("R4 no repeat", seen == 0, 64'(seen), 64'd0);

    // R3 and R5: active-low level entry, pin low, single delivery with R2 fields
    pinIn[1] = 1'b0;
    writeEntry(1, mkEntry(8'h05, 1'b0, 1'b1, 1'b1, 1'b1, 3'd2, 8'h42));
    countVec("R3 active low", 8'h42, 8, seen);
    check("R5 single level delivery", seen == 1, 64'(seen), 64'd1);
    checkRead("R5 rirr set", 1, mkEntry(8'h05, 1'b0, 1'b1, 1'b1, 1'b1, 3'd2, 8'h42) | 64'h4000);

    // R6: non-matching broadcast leaves the bit
    eoiValid = 1'b1; eoiVector = 8'h99;
    step("R6 mismatch");
    checkRead("R6 rirr kept", 1, mEntry[1]);
    check("R6 rirr still set", regRdData[14] === 1'b1, {63'b0, regRdData[14]}, 64'd1);

    // R7: matching broadcast with the pin still active re-delivers
    eoiValid = 1'b1; eoiVector = 8'h42;
    countVec("R7 redeliver", 8'h42, 4, seen);
    check("R7 one redelivery", seen == 1, 64'(seen), 64'd1);

    // R8: masked edge request held, then released by unmask
    writeEntry(2, mkEntry(8'h07, 1'b1, 1'b0, 1'b0, 1'b0, 3'd1, 8'h50));
    step("R8 write");
    pinIn[2] = 1'b1;
    countVec("R8 masked", 8'h50, 4, seen);
    check("R8 masked silent", seen == 0, 64'(seen), 64'd0);
    writeEntry(2, mkEntry(8'h07, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 8'h50));
    countVec("R8 unmasked", 8'h50, 4, seen);
    check("R8 held request", seen == 1, 64'(seen), 64'd1);

    // R9: two simultaneous edges leave in index order
    writeEntry(3, mkEntry(8'h03, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 8'h63));
    step("R9 write3");
    writeEntry(4, mkEntry(8'h04, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 8'h64));
    step("R9 write4");
    pinIn[4:3] = 2'b11;
    step("R9 sample");
    step("R9 first");
    check("R9 lower first", msgValid === 1'b1 && msgVector === 8'h63, {55'b0, msgValid, msgVector}, {55'b0, 1'b1, 8'h63});
    step("R9 second");
    check("R9 higher next", msgValid === 1'b1 && msgVector === 8'h64, {55'b0, msgValid, msgVector}, {55'b0, 1'b1, 8'h64});

    // random phase against the model
    for (int c = 0; c < 4000; c++) begin
      for (int b = 0; b < NP; b++) if ($urandom_range(7) == 0) pinIn[b] = ~pinIn[b];
      if ($urandom_range(15) == 0) begin
        logic [7:0] v;
        case ($urandom_range(3))
          0: v = 8'h31; 1: v = 8'h42; 2: v = 8'h50; default: v = 8'h63;
        endcase
        writeEntry($urandom_range(NP - 1),
                   mkEntry(8'($urandom), ($urandom_range(3) == 0), 1'($urandom), 1'($urandom),
                           1'($urandom), 3'($urandom), v) | (64'($urandom) << 17 & 64'h00FF_FFFF_FFFE_0000)
                   | ({63'b0, 1'($urandom)} << 14) | ({63'b0, 1'($urandom)} << 12));
      end
      if ($urandom_range(5) == 0) begin
        eoiValid = 1'b1;
        case ($urandom_range(3))
          0: eoiVector = 8'h31; 1: eoiVector = 8'h42; 2: eoiVector = 8'h50; default: eoiVector = 8'h63;
        endcase
      end
      step("R2 random");
      if (c % 40 == 0) begin
        int a = $urandom_range(NP - 1);
        checkRead("R11 readback", a, mEntry[a]);
      end
    end

    finishRun();
  end
endmodule